// File: doc/BRIEF.md
# Two-Level Routed Event Interrupt Controller

This block collects 64 event inputs and steers them onto 10 host interrupt lines. Each event is first conditioned: a polarity bit decides which input level counts as active, and a type bit picks edge-capture or level behaviour. The result is a pending bit per event. Pending and enabled events then pass through two programmable many-to-one tables. The first table assigns every event to one of 10 channels. The second table assigns every channel to one of 10 hosts.

Each host sees the winning event among those routed to it. The winner is decided by fixed priority: lowest channel number first, then lowest event number within that channel. A host interrupt line is raised when any event routed to it is live, gated by a global enable and a per-host enable.

Software reaches the block through a word-addressed register port with a combinational read. Besides direct 32-bit access to the pending and enable vectors, it has four index ports. Writing an event number to one of them sets or clears one pending or enable bit without a read-modify-write.

Top module: `irq_router`

## Requirements
- R1: After reset the channel and host tables, pending, enable, type, global enable and host enables are all zero and polarity is all ones; every host winner word (word 48+h) reads 0x80000000 and no hostIrq bit is set.
- R2: Event e's channel sits in word 16+e/4, byte e%4 (bits 8*(e%4)+7 down to 8*(e%4)); channel c's host sits in word 32+c/4, byte c%4; a channel field of 10 or more or a host field of 10 or more routes nowhere; all table words read back as written.
- R3: Writing event number n to word 2 sets pending bit n; writing n to word 3 clears it (when no hardware set arrives in the same cycle).
- R4: Writing n to word 4 sets enable bit n and writing n to word 5 clears it, leaving every other enable bit unchanged.
- R5: A write to words 2 to 5 whose data is 64 or more (any of bits 31:6 set) changes neither the pending nor the enable vector.
- R6: Words 8/9 read pending bits 31:0/63:32, and writing 1 to a bit clears it while 0 leaves it; words 10/11 read and write enable bits 31:0/63:32 directly.
- R7: Words 12/13 hold polarity (1 = active high) and words 14/15 type (0 = edge, 1 = level). For an edge-type event, an inactive-to-active change of the input sets pending at the next clock edge, and the bit stays set after the input returns inactive.
- R8: For a level-type event, pending is forced set on every clock edge at which the adjusted input is active, so a clear only takes effect while the input is inactive; a software set on an inactive level event persists until cleared.
- R9: Word 48+h returns bit 31 = 1 and bits 9:0 = 0 when no pending-and-enabled event routes to host h; otherwise bit 31 = 0 and bits 9:0 = the event in the lowest-numbered channel mapped to h, lowest event number within it.
- R10: hostIrq[h] is high exactly when word 0 bit 0 is 1, word 1 bit h is 1, and host h has a winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 64 | Raw event inputs |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| hostIrq | output | 10 | Host interrupt lines |

## Verification
The routing check is swept over four table patterns. In these patterns the channel and host fields include out-of-range values, and the pending and enable vectors overlap in varied ways. Comparing every host's winner word against an arithmetic model separates channel-first ordering from event-first ordering and catches wrong out-of-range handling. The index ports are walked over all 64 events, and then written with over-range values, to expose decoding of the wrong bits. Edge and level inputs are driven under both polarities, which distinguishes sticky capture from level tracking and shows whether an acknowledge is overridden by an active level.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int IDX_W = 6;

  localparam int W_GLOB = 0;
  localparam int W_HEN  = 1;
  localparam int W_SSET = 2;
  localparam int W_SCLR = 3;
  localparam int W_ESET = 4;
  localparam int W_ECLR = 5;
  localparam int W_STS  = 8;
  localparam int W_EN   = 10;
  localparam int W_POL  = 12;
  localparam int W_TYP  = 14;
  localparam int W_CMAP = 16;
  localparam int W_HMAP = 32;
  localparam int W_PRIO = 48;

  typedef struct packed {
    logic globWr;
    logic hostEnWr;
    logic stsSet;
    logic stsClr;
    logic enSet;
    logic enClr;
    logic stsW1c;
    logic enWr;
    logic polWr;
    logic typWr;
    logic cmapWr;
    logic hmapWr;
    logic [IDX_W-1:0] idx;
    logic [4:0] sel;
  } ctrlStrobe_t;

  function automatic logic inWin(input logic [31:0] w, input int base, input int cnt);
    return (w >= 32'(base)) && (w < 32'(base + cnt));
  endfunction

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_EVT = 64,
  parameter int NUM_CHN = 10,
  parameter int ADDR_W  = 6
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output ctrlStrobe_t       strb
);
  localparam int EVT_WORDS = NUM_EVT / 32;
  localparam int CMAP_REGS = NUM_EVT / 4;
  localparam int HMAP_REGS = (NUM_CHN + 3) / 4;

  logic [31:0] wordNum;
  logic        idxOk;

  assign wordNum = 32'(regAddr);
  assign idxOk   = regWdata < 32'(NUM_EVT);

  always_comb begin
    strb     = '0;
    strb.idx = regWdata[IDX_W-1:0];
    if (regWe) begin
      if (wordNum == 32'(W_GLOB))      strb.globWr   = 1'b1;
      else if (wordNum == 32'(W_HEN))  strb.hostEnWr = 1'b1;
      else if (wordNum == 32'(W_SSET)) strb.stsSet   = idxOk;
      else if (wordNum == 32'(W_SCLR)) strb.stsClr   = idxOk;
      else if (wordNum == 32'(W_ESET)) strb.enSet    = idxOk;
      else if (wordNum == 32'(W_ECLR)) strb.enClr    = idxOk;
      else if (inWin(wordNum, W_STS, EVT_WORDS)) begin
        strb.stsW1c = 1'b1;
        strb.sel    = 5'(wordNum - 32'(W_STS));
      end else if (inWin(wordNum, W_EN, EVT_WORDS)) begin
        strb.enWr = 1'b1;
        strb.sel  = 5'(wordNum - 32'(W_EN));
      end else if (inWin(wordNum, W_POL, EVT_WORDS)) begin
        strb.polWr = 1'b1;
        strb.sel   = 5'(wordNum - 32'(W_POL));
      end else if (inWin(wordNum, W_TYP, EVT_WORDS)) begin
        strb.typWr = 1'b1;
        strb.sel   = 5'(wordNum - 32'(W_TYP));
      end else if (inWin(wordNum, W_CMAP, CMAP_REGS)) begin
        strb.cmapWr = 1'b1;
        strb.sel    = 5'(wordNum - 32'(W_CMAP));
      end else if (inWin(wordNum, W_HMAP, HMAP_REGS)) begin
        strb.hmapWr = 1'b1;
        strb.sel    = 5'(wordNum - 32'(W_HMAP));
      end
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CHN  = 10,
  parameter int NUM_HOST = 10,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  ctrlStrobe_t         strb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic [NUM_HOST-1:0] hostIrq,
  output logic [NUM_EVT-1:0]  statusVec,
  output logic [NUM_EVT-1:0]  enableVec,
  output logic [NUM_HOST-1:0] prioNone
);
  localparam int EVT_WORDS = NUM_EVT / 32;
  localparam int CMAP_REGS = NUM_EVT / 4;
  localparam int HMAP_REGS = (NUM_CHN + 3) / 4;
  localparam int HMAP_ENT  = HMAP_REGS * 4;

  logic [NUM_EVT-1:0]  status, enable, polarity, evType, prevAdj;
  logic [7:0]          chanMap [NUM_EVT];
  logic [7:0]          hostMap [HMAP_ENT];
  logic                globEn;
  logic [NUM_HOST-1:0] hostEn;

  logic [NUM_EVT-1:0]  adj, hwSet, swSet, swClr, w1cMask, statusNext, live;
  logic [NUM_EVT-1:0]  oneHot;
  logic                chAny [NUM_CHN];
  logic [9:0]          chEvt [NUM_CHN];
  logic [NUM_HOST-1:0] hAny;
  logic [9:0]          hEvt [NUM_HOST];
  logic [31:0]         wordNum;

  // conditioning and pending update
  assign adj    = ~(evtIn ^ polarity);
  assign hwSet  = (~evType & adj & ~prevAdj) | (evType & adj);
  assign oneHot = {{(NUM_EVT-1){1'b0}}, 1'b1} << strb.idx;
  assign swSet  = strb.stsSet ? oneHot : '0;
  assign swClr  = strb.stsClr ? oneHot : '0;

  always_comb begin
    w1cMask = '0;
    for (int w = 0; w < EVT_WORDS; w++)
      if (strb.stsW1c && strb.sel == 5'(w)) w1cMask[w*32 +: 32] = regWdata;
  end

  assign statusNext = (status & ~swClr & ~w1cMask) | swSet | hwSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status   <= '0;
      enable   <= '0;
      polarity <= '1;
      evType   <= '0;
      prevAdj  <= '0;
      globEn   <= 1'b0;
      hostEn   <= '0;
      for (int e = 0; e < NUM_EVT; e++) chanMap[e] <= '0;
      for (int c = 0; c < HMAP_ENT; c++) hostMap[c] <= '0;
    end else begin
      status  <= statusNext;
      prevAdj <= adj;
      if (strb.globWr)   globEn <= regWdata[0];
      if (strb.hostEnWr) hostEn <= regWdata[NUM_HOST-1:0];
      for (int w = 0; w < EVT_WORDS; w++) begin
        if (strb.enWr  && strb.sel == 5'(w)) enable[w*32 +: 32]   <= regWdata;
        if (strb.polWr && strb.sel == 5'(w)) polarity[w*32 +: 32] <= regWdata;
        if (strb.typWr && strb.sel == 5'(w)) evType[w*32 +: 32]   <= regWdata;
      end
      if (strb.enSet) enable[strb.idx] <= 1'b1;
      if (strb.enClr) enable[strb.idx] <= 1'b0;
      for (int r = 0; r < CMAP_REGS; r++)
        if (strb.cmapWr && strb.sel == 5'(r))
          for (int b = 0; b < 4; b++) chanMap[r*4+b] <= regWdata[b*8 +: 8];
      for (int r = 0; r < HMAP_REGS; r++)
        if (strb.hmapWr && strb.sel == 5'(r))
          for (int b = 0; b < 4; b++) hostMap[r*4+b] <= regWdata[b*8 +: 8];
    end
  end

  // priority resolution: channel first, event second
  assign live = status & enable;

  always_comb begin
    for (int c = 0; c < NUM_CHN; c++) begin
      chAny[c] = 1'b0;
      chEvt[c] = '0;
      for (int e = NUM_EVT - 1; e >= 0; e--) begin
        if (live[e] && chanMap[e] == 8'(c)) begin
          chAny[c] = 1'b1;
          chEvt[c] = 10'(e);
        end
      end
    end
    for (int h = 0; h < NUM_HOST; h++) begin
      hAny[h] = 1'b0;
      hEvt[h] = '0;
      for (int c = NUM_CHN - 1; c >= 0; c--) begin
        if (chAny[c] && hostMap[c] == 8'(h)) begin
          hAny[h] = 1'b1;
          hEvt[h] = chEvt[c];
        end
      end
    end
  end

  assign hostIrq   = {NUM_HOST{globEn}} & hostEn & hAny;
  assign prioNone  = ~hAny;
  assign statusVec = status;
  assign enableVec = enable;

  // read mux
  assign wordNum = 32'(regAddr);

  always_comb begin
    regRdata = '0;
    if (wordNum == 32'(W_GLOB)) regRdata[0] = globEn;
    if (wordNum == 32'(W_HEN))  regRdata[NUM_HOST-1:0] = hostEn;
    for (int w = 0; w < EVT_WORDS; w++) begin
      if (wordNum == 32'(W_STS + w)) regRdata = status[w*32 +: 32];
      if (wordNum == 32'(W_EN + w))  regRdata = enable[w*32 +: 32];
      if (wordNum == 32'(W_POL + w)) regRdata = polarity[w*32 +: 32];
      if (wordNum == 32'(W_TYP + w)) regRdata = evType[w*32 +: 32];
    end
    for (int r = 0; r < CMAP_REGS; r++)
      if (wordNum == 32'(W_CMAP + r))
        regRdata = {chanMap[r*4+3], chanMap[r*4+2], chanMap[r*4+1], chanMap[r*4]};
    for (int r = 0; r < HMAP_REGS; r++)
      if (wordNum == 32'(W_HMAP + r))
        regRdata = {hostMap[r*4+3], hostMap[r*4+2], hostMap[r*4+1], hostMap[r*4]};
    for (int h = 0; h < NUM_HOST; h++)
      if (wordNum == 32'(W_PRIO + h))
        regRdata = {~hAny[h], 21'b0, hEvt[h]};
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CHN  = 10,
  parameter int NUM_HOST = 10,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic [NUM_HOST-1:0] hostIrq
);
  ctrlStrobe_t         strb;
  logic [NUM_EVT-1:0]  statusVec;
  logic [NUM_EVT-1:0]  enableVec;
  logic [NUM_HOST-1:0] prioNone;

  irq_router_ctrl #(
    .NUM_EVT(NUM_EVT), .NUM_CHN(NUM_CHN), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .strb(strb)
  );

  irq_router_dp #(
    .NUM_EVT(NUM_EVT), .NUM_CHN(NUM_CHN), .NUM_HOST(NUM_HOST), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hostIrq(hostIrq),
    .statusVec(statusVec), .enableVec(enableVec), .prioNone(prioNone)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_EVT  = 64,
  parameter int NUM_HOST = 10,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regWdata,
  input logic [NUM_HOST-1:0] hostIrq,
  input logic [NUM_EVT-1:0]  statusVec,
  input logic [NUM_EVT-1:0]  enableVec,
  input logic [NUM_HOST-1:0] prioNone
);
  localparam int IW = $clog2(NUM_EVT);

  logic [31:0] wordNum;
  logic        inRange;
  logic        lastSsSet, lastEnSet, lastEnClr, lastOob;
  logic [IW-1:0] lastIdx;

  assign wordNum = 32'(regAddr);
  assign inRange = regWdata < 32'(NUM_EVT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSsSet <= 1'b0;
      lastEnSet <= 1'b0;
      lastEnClr <= 1'b0;
      lastOob   <= 1'b0;
      lastIdx   <= '0;
    end else begin
      lastSsSet <= regWe && wordNum == 32'd2 && inRange;
      lastEnSet <= regWe && wordNum == 32'd4 && inRange;
      lastEnClr <= regWe && wordNum == 32'd5 && inRange;
      lastOob   <= regWe && wordNum >= 32'd2 && wordNum <= 32'd5 && !inRange;
      lastIdx   <= regWdata[IW-1:0];
    end
  end

  a_r3_index_set: assert property (@(posedge clk) disable iff (!rstN)
    lastSsSet |-> statusVec[lastIdx]);

  a_r4_index_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    lastEnSet |-> enableVec[lastIdx]);

  a_r4_index_enable_clr: assert property (@(posedge clk) disable iff (!rstN)
    lastEnClr |-> !enableVec[lastIdx]);

  a_r5_oob_ignored: assert property (@(posedge clk) disable iff (!rstN)
    lastOob |-> $stable(enableVec));

  a_r10_irq_has_winner: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq & prioNone) == '0);

endmodule

bind irq_router irq_router_chk #(
  .NUM_EVT(NUM_EVT), .NUM_HOST(NUM_HOST), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  localparam int NE = 64;
  localparam int NC = 10;
  localparam int NH = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NE-1:0] evtIn = '0;
  logic          regWe = 1'b0;
  logic [5:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NH-1:0] hostIrq;

  int nChk = 0;
  int nFail = 0;

  logic [63:0] sSts, sEn;
  logic [7:0]  sCmap [NE];
  logic [7:0]  sHmap [12];

  irq_router u_irq_router (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hostIrq(hostIrq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic chkRd(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic chkStsEn(input string req);
    chkRd(req, 6'd8,  sSts[31:0]);
    chkRd(req, 6'd9,  sSts[63:32]);
    chkRd(req, 6'd10, sEn[31:0]);
    chkRd(req, 6'd11, sEn[63:32]);
  endtask

  function automatic logic [31:0] expPrio(input int h);
    for (int c = 0; c < NC; c++) begin
      if (sHmap[c] == 8'(h)) begin
        for (int e = 0; e < NE; e++)
          if (sSts[e] && sEn[e] && sCmap[e] == 8'(c)) return 32'(e);
      end
    end
    return 32'h8000_0000;
  endfunction

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [63:0] pend, ena;
    logic [NH-1:0] expIrq;
    sSts = '0; sEn = '0;
    for (int e = 0; e < NE; e++) sCmap[e] = '0;
    for (int c = 0; c < 12; c++) sHmap[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkRd("R1 glob", 6'd0, 32'h0);
    chkRd("R1 hosten", 6'd1, 32'h0);
    chkStsEn("R1 sts/en");
    chkRd("R1 pol0", 6'd12, 32'hFFFF_FFFF);
    chkRd("R1 pol1", 6'd13, 32'hFFFF_FFFF);
    chkRd("R1 typ0", 6'd14, 32'h0);
    chkRd("R1 typ1", 6'd15, 32'h0);
    for (int r = 0; r < 19; r++) chkRd("R1 maps", 6'(16 + r), 32'h0);
    for (int h = 0; h < NH; h++) chkRd("R1 prio", 6'(48 + h), 32'h8000_0000);
    chk("R1 hostIrq", 32'(hostIrq), 32'h0);

    // R4 index enable set and clear over all events
    for (int e = 0; e < NE; e++) begin
      wr(6'd4, 32'(e));
      sEn[e] = 1'b1;
      chkRd("R4 set lo", 6'd10, sEn[31:0]);
      chkRd("R4 set hi", 6'd11, sEn[63:32]);
    end
    for (int e = 0; e < NE; e += 2) begin
      wr(6'd5, 32'(e));
      sEn[e] = 1'b0;
    end
    chkStsEn("R4 clear even");

    // R3 index status set and clear
    for (int e = 0; e < NE; e++) begin
      wr(6'd2, 32'(e));
      sSts[e] = 1'b1;
    end
    chkStsEn("R3 set all");
    for (int e = 1; e < NE; e += 2) begin
      wr(6'd3, 32'(e));
      sSts[e] = 1'b0;
    end
    chkStsEn("R3 clear odd");

    // R5 out-of-range indices ignored
    wr(6'd2, 32'd64);
    wr(6'd3, 32'd100);
    wr(6'd4, 32'h0000_0100);
    wr(6'd5, 32'hFFFF_FFFF);
    wr(6'd3, 32'h8000_0000);
    chkStsEn("R5 oob");

    // R6 direct word access
    wr(6'd8, 32'h0000_FFFF);
    sSts[15:0] = '0;
    wr(6'd9, 32'h0000_0000);
    wr(6'd10, 32'hDEAD_BEEF);
    wr(6'd11, 32'h1234_5678);
    sEn = 64'h1234_5678_DEAD_BEEF;
    chkStsEn("R6 w1c/direct");

    // R2 R9 R10 routing sweep
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < NE; e++) sCmap[e] = 8'((e * (p + 3) + p) % 12);
      for (int c = 0; c < 12; c++) sHmap[c] = 8'((c * (p + 7) + 1) % 11);
      for (int r = 0; r < 16; r++)
        wr(6'(16 + r), {sCmap[4*r+3], sCmap[4*r+2], sCmap[4*r+1], sCmap[4*r]});
      for (int r = 0; r < 3; r++)
        wr(6'(32 + r), {sHmap[4*r+3], sHmap[4*r+2], sHmap[4*r+1], sHmap[4*r]});
      for (int r = 0; r < 16; r++)
        chkRd("R2 cmap readback", 6'(16 + r),
              {sCmap[4*r+3], sCmap[4*r+2], sCmap[4*r+1], sCmap[4*r]});
      pend = {64'hA5C3_0F96_5A3C_F069} >> (p * 5) | (64'h1 << (63 - p));
      ena  = (p == 3) ? 64'h0 : ~(64'h9249_2492_4924_9249 << p);
      wr(6'd8, 32'hFFFF_FFFF);
      wr(6'd9, 32'hFFFF_FFFF);
      for (int e = 0; e < NE; e++) if (pend[e]) wr(6'd2, 32'(e));
      wr(6'd10, ena[31:0]);
      wr(6'd11, ena[63:32]);
      sSts = pend; sEn = ena;
      for (int h = 0; h < NH; h++) chkRd("R9 R2 prio", 6'(48 + h), expPrio(h));
      wr(6'd0, 32'h1);
      wr(6'd1, 32'h3FF);
      expIrq = '0;
      for (int h = 0; h < NH; h++) expIrq[h] = !expPrio(h)[31];
      chk("R10 all hosts", 32'(hostIrq), 32'(expIrq));
      wr(6'd1, 32'h155);
      chk("R10 host mask", 32'(hostIrq), 32'(expIrq & 10'h155));
      wr(6'd0, 32'h0);
      chk("R10 global off", 32'(hostIrq), 32'h0);
      chkRd("R10 prio unaffected by gate", 6'd48, expPrio(0));
    end

    // R7 edge capture, active high
    wr(6'd8, 32'hFFFF_FFFF);
    wr(6'd9, 32'hFFFF_FFFF);
    sSts = '0;
    for (int e = 0; e < NE; e++) begin
      @(negedge clk); evtIn[e] = 1'b1;
      sSts[e] = 1'b1;
      chkRd("R7 edge set", 6'(8 + e / 32), sSts[(e/32)*32 +: 32]);
      evtIn[e] = 1'b0;
      chkRd("R7 sticky", 6'(8 + e / 32), sSts[(e/32)*32 +: 32]);
      wr(6'd3, 32'(e));
      sSts[e] = 1'b0;
      chkRd("R7 ack", 6'(8 + e / 32), sSts[(e/32)*32 +: 32]);
    end

    // R7 active low
    @(negedge clk); evtIn = '1;
    @(negedge clk);
    wr(6'd12, 32'h0);
    wr(6'd13, 32'h0);
    wr(6'd8, 32'hFFFF_FFFF);
    wr(6'd9, 32'hFFFF_FFFF);
    sSts = '0;
    chkStsEn("R7 low idle");
    @(negedge clk); evtIn[33] = 1'b0;
    sSts[33] = 1'b1;
    chkStsEn("R7 low edge");
    @(negedge clk); evtIn = '0;
    @(negedge clk);
    wr(6'd12, 32'hFFFF_FFFF);
    wr(6'd13, 32'hFFFF_FFFF);
    wr(6'd8, 32'hFFFF_FFFF);
    wr(6'd9, 32'hFFFF_FFFF);
    sSts = '0;
    chkStsEn("R7 restore");

    // R8 level type
    wr(6'd14, 32'h0000_0020);
    wr(6'd15, 32'h0000_0100);
    @(negedge clk); evtIn[5] = 1'b1; evtIn[40] = 1'b1;
    sSts[5] = 1'b1; sSts[40] = 1'b1;
    chkStsEn("R8 level set");
    wr(6'd3, 32'd5);
    wr(6'd3, 32'd40);
    chkStsEn("R8 ack while active");
    @(negedge clk); evtIn[5] = 1'b0;
    @(negedge clk);
    chkStsEn("R8 holds after drop");
    wr(6'd3, 32'd5);
    sSts[5] = 1'b0;
    chkStsEn("R8 ack inactive");
    wr(6'd2, 32'd5);
    sSts[5] = 1'b1;
    @(negedge clk);
    chkStsEn("R8 sw set inactive");
    @(negedge clk); evtIn[40] = 1'b0;
    wr(6'd8, 32'h0000_0020);
    wr(6'd3, 32'd40);
    sSts[5] = 1'b0; sSts[40] = 1'b0;
    chkStsEn("R8 final clear");

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule